// File: doc/BRIEF.md
# Serial Byte Memory Target with Programming Delay

This block is a two-wire serial bus target in front of a 4096-byte memory. It is built for a chip's own microcontroller. SCL and SDA are oversampled on a fast system clock. The block pulls SDA low through an output enable and releases it otherwise. A transaction begins at START. The host sends a device byte, which carries a fixed identifier, three strap bits and a direction bit. It then sends a two-byte word address, and after that the data.

Writes are collected in a 64-entry page buffer. They are committed to the array when STOP arrives, and committing starts a programming interval. For the length of that interval the block refuses its own device byte, so a host can poll until the block answers. Reads follow an internal address pointer. A current-address read uses the pointer as it stands. A random read sets the pointer with an address-only write followed by a repeated START. A sequential read continues for as long as the host acknowledges.

An external `reset_active` input forces the bus logic idle without disturbing a programming interval that has already started.

Top module: `i2c_mem_target`

## Requirements
- R1: The device byte is {4'b1010, strap[2:0], rw}, MSB first, with rw=1 meaning read. Only a device byte that matches gets an acknowledge (SDA held low during the ninth SCL pulse). A byte that does not match is left unacknowledged.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bus activity before a START is ignored, including a matching device byte.
- R3: In a write, both word-address bytes (high byte first) and every data byte receive an acknowledge.
- R4: The memory address is the low 12 bits of the 16-bit word address, and the upper 4 bits have no effect. A single data byte followed by STOP stores that byte at the address.
- R5: In a write, only the low 6 address bits advance after each data byte, and the upper 6 bits stay fixed. A 65th byte or later wraps within the page and replaces the byte written earlier at that offset.
- R6: Buffered data is committed only at STOP. For PROG_CYCLES system clocks after that, the block acknowledges nothing.
- R7: The address pointer holds the last accessed address plus one. A current-address read returns the byte there, and the pointer rolls over from 4095 to 0.
- R8: A random read (address-only write, repeated START, read device byte) returns the addressed byte. Each host acknowledge brings the next byte. After a host NACK the block drives nothing until the next START.
- R9: While reset_active is high, any transaction in progress is abandoned, its buffered data is discarded and no byte is acknowledged. A programming interval already started still runs to completion and commits its data.
- R10: SDA drive changes only while SCL is low, a few system clocks after the SCL falling edge. The exception is release forced by reset_active.
- R11: A write that ends with STOP right after the word address loads the pointer and starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap | input | 3 | Device address strap bits |
| reset_active | input | 1 | External reset condition; aborts bus activity |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
On every cycle the assertions check four things. SDA drive moves only while the sampled SCL is low. Nothing is driven while reset_active is set or while a programming interval is counting. The interval counter steps down by exactly one per clock. The page bits of the pointer hold still across a write burst. The directed scenarios cover what only stored data can reveal: which byte landed where after wrap and rollover, whether polling is refused during programming, whether an aborted write stayed out of the array, and whether an interval interrupted by reset_active still committed its data.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int          MEM_AW      = 12,
  parameter int          PAGE_AW     = 6,
  parameter int          PROG_CYCLES = 1_250_000,
  parameter logic [3:0]  DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       reset_active,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam int HW    = MEM_AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_WAIT} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  wire        scl_s = scl_m[1];
  wire        sda_s = sda_m[1];
  wire        scl_rise = scl_s & ~scl_q;
  wire        scl_fall = ~scl_s & scl_q;
  wire        start = scl_s & scl_q & sda_q & ~sda_s;
  wire        stop  = scl_s & scl_q & ~sda_q & sda_s;

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pvalid;
  logic [MEM_AW-1:0] acnt;
  logic [HW-1:0]     ahi;
  logic [7:0]        sh, tx;
  logic [3:0]        bitc;
  logic [1:0]        ph;
  logic              rd, mack, commit;
  logic [CW-1:0]     cnt;
  st_t               st;

  wire [7:0] rdata  = mem[acnt];
  wire       got8   = (st == S_RX) && scl_fall && (bitc == 4'd8);
  wire       byte_wr = !reset_active && !start && !stop && got8 && (ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i}; sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s; sda_q <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sda_oe <= 1'b0; pvalid <= '0; acnt <= '0; ahi <= '0;
      sh <= '0; tx <= '0; bitc <= '0; ph <= '0; rd <= 1'b0; mack <= 1'b0;
      commit <= 1'b0; cnt <= '0;
    end else begin
      commit <= 1'b0;
      if (commit) pvalid <= '0;
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (reset_active) begin
        st <= S_IDLE; sda_oe <= 1'b0; pvalid <= '0;
      end else if (start) begin
        st <= S_RX; ph <= '0; bitc <= '0; sda_oe <= 1'b0; pvalid <= '0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        if (|pvalid) begin commit <= 1'b1; cnt <= CW'(PROG_CYCLES); end
      end else begin
        case (st)
          S_RX:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; bitc <= bitc + 4'd1;
            end else if (got8) begin
              bitc <= '0; st <= S_ACK; sda_oe <= 1'b1;
              case (ph)
                2'd0: if (sh[7:1] == {DEV_ID, strap} && cnt == '0) begin
                        rd <= sh[0];
                        if (!sh[0]) ph <= 2'd1;
                      end else begin
                        st <= S_WAIT; sda_oe <= 1'b0;
                      end
                2'd1: begin ahi <= sh[HW-1:0]; ph <= 2'd2; end
                2'd2: begin acnt <= {ahi, sh}; ph <= 2'd3; end
                default: begin
                  pvalid[acnt[PAGE_AW-1:0]] <= 1'b1;
                  acnt[PAGE_AW-1:0] <= acnt[PAGE_AW-1:0] + PAGE_AW'(1);
                end
              endcase
            end
          S_ACK, S_MACK:
            if (scl_rise && st == S_MACK) mack <= ~sda_s;
            else if (scl_fall) begin
              sda_oe <= 1'b0;
              if ((st == S_ACK && rd && ph == 2'd0) || (st == S_MACK && mack)) begin
                sda_oe <= ~rdata[7]; tx <= {rdata[6:0], 1'b1};
                acnt <= acnt + MEM_AW'(1); bitc <= '0; st <= S_TX;
              end else
                st <= (st == S_ACK) ? S_RX : S_WAIT;
            end
          S_TX:
            if (scl_rise) bitc <= bitc + 4'd1;
            else if (scl_fall) begin
              if (bitc == 4'd8) begin sda_oe <= 1'b0; st <= S_MACK; end
              else begin sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b1}; end
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (byte_wr) pbuf[acnt[PAGE_AW-1:0]] <= sh;

  always_ff @(posedge clk)
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i]) mem[{acnt[MEM_AW-1:PAGE_AW], PAGE_AW'(i)}] <= pbuf[i];

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(reset_active)) |-> !$past(scl_s));
  a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reset_active) |-> !sda_oe);
  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> !sda_oe);
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3 && $past(ph) == 2'd3) |-> $stable(acnt[MEM_AW-1:PAGE_AW]));
endmodule

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int PROG = 1500;
  localparam int HT   = 12;
  localparam logic [7:0] WADR = 8'hAA, RADR = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, reset_active = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   nchk = 0, nfail = 0, viol = 0;
  bit   done = 1'b0;
  logic [7:0] wdat [70];
  logic [7:0] rdat [8];

  always #2 clk = ~clk;

  i2c_mem_target #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap(strap),
    .reset_active(reset_active), .sda_oe(sda_oe));

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m && !reset_active) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic hp; repeat (HT) @(negedge clk); endtask
  task automatic i_start; sda_m = 1; hp; scl_m = 1; hp; sda_m = 0; hp; scl_m = 0; hp; endtask
  task automatic i_stop; sda_m = 0; hp; scl_m = 1; hp; sda_m = 1; hp; endtask
  task automatic wbit(input bit b); sda_m = b; hp; scl_m = 1; hp; scl_m = 0; hp; endtask
  task automatic rbit(output bit b); sda_m = 1; hp; scl_m = 1; hp; b = sda_line; scl_m = 0; hp; endtask
  task automatic sendb(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b); ack = !b;
  endtask
  task automatic recvb(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(!ack);
  endtask

  task automatic wr(input logic [15:0] a, input int n, input string tag);
    bit ack;
    i_start;
    sendb(WADR, ack);   chk(ack, {tag, " R1 dev ack"}, ack, 1);
    sendb(a[15:8], ack); chk(ack, {tag, " R3 addr hi ack"}, ack, 1);
    sendb(a[7:0], ack);  chk(ack, {tag, " R3 addr lo ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendb(wdat[i], ack);
      if (!ack) chk(ack, {tag, " R3 data ack"}, i, 1);
    end
    i_stop;
  endtask
  task automatic rd_rand(input logic [15:0] a, input int n);
    bit ack;
    i_start; sendb(WADR, ack); sendb(a[15:8], ack); sendb(a[7:0], ack);
    i_start; sendb(RADR, ack); chk(ack, "R8 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) recvb(rdat[i], i < n - 1);
    i_stop;
  endtask
  task automatic settle; repeat (PROG + 50) @(negedge clk); endtask

  task automatic t_reset_and_addr;
    bit ack, b;
    chk(sda_oe == 0, "R2 reset idle", sda_oe, 0);
    for (int i = 7; i >= 0; i--) wbit(WADR[i]);
    rbit(b); chk(b == 1, "R2 no ack before START", !b, 0);
    i_start; sendb(8'hA2, ack); i_stop;
    chk(!ack, "R1 strap mismatch nack", ack, 0);
    i_start; sendb(8'hBA, ack); i_stop;
    chk(!ack, "R1 id mismatch nack", ack, 0);
  endtask
  task automatic t_byte_write_poll;
    bit ack;
    wdat[0] = 8'h5A; wr(16'hF123, 1, "byte");
    i_start; sendb(WADR, ack); i_stop;
    chk(!ack, "R6 busy poll nack", ack, 0);
    settle;
    i_start; sendb(WADR, ack); i_stop;
    chk(ack, "R6 ack after programming", ack, 1);
    rd_rand(16'h0123, 1); chk(rdat[0] == 8'h5A, "R4 byte stored upper bits ignored", rdat[0], 8'h5A);
  endtask
  task automatic t_page_wrap;
    for (int i = 0; i < 66; i++) wdat[i] = 8'(8'h10 + i);
    wr(16'h0140, 66, "page"); settle;
    rd_rand(16'h0140, 4);
    chk(rdat[0] == 8'h50, "R5 wrap overwrite off0", rdat[0], 8'h50);
    chk(rdat[1] == 8'h51, "R5 wrap overwrite off1", rdat[1], 8'h51);
    chk(rdat[2] == 8'h12, "R8 sequential off2", rdat[2], 8'h12);
    chk(rdat[3] == 8'h13, "R8 sequential off3", rdat[3], 8'h13);
    wdat[0] = 8'hAA; wdat[1] = 8'hBB; wdat[2] = 8'hCC;
    wr(16'h017E, 3, "edge"); settle;
    rd_rand(16'h0140, 1); chk(rdat[0] == 8'hCC, "R5 low bits wrap to page start", rdat[0], 8'hCC);
    rd_rand(16'h017F, 1); chk(rdat[0] == 8'hBB, "R5 last page byte", rdat[0], 8'hBB);
  endtask
  task automatic t_rollover;
    bit ack, b;
    logic [7:0] v;
    wdat[0] = 8'hC3; wr(16'h0FFF, 1, "top"); settle;
    wdat[0] = 8'h3C; wr(16'h0000, 1, "bot"); settle;
    rd_rand(16'h0FFF, 2);
    chk(rdat[0] == 8'hC3 && rdat[1] == 8'h3C, "R7 sequential rolls 4095->0", {rdat[0], rdat[1]}, 16'hC33C);
    rd_rand(16'h0FFF, 1);
    i_start; sendb(RADR, ack); recvb(v, 1'b0);
    rbit(b); chk(b == 1, "R8 released after NACK", !b, 0);
    i_stop;
    chk(v == 8'h3C, "R7 current address after 4095", v, 8'h3C);
  endtask
  task automatic t_addr_only;
    bit ack;
    logic [7:0] v;
    wr(16'h0123, 0, "aonly");
    i_start; sendb(WADR, ack); i_stop;
    chk(ack, "R11 no programming after address-only", ack, 1);
    i_start; sendb(RADR, ack); recvb(v, 1'b0); i_stop;
    chk(v == 8'h5A, "R11 pointer loaded", v, 8'h5A);
  endtask
  task automatic t_reset_active;
    bit ack;
    wdat[0] = 8'h11; wr(16'h0200, 1, "pre"); settle;
    i_start; sendb(WADR, ack); sendb(8'h02, ack); sendb(8'h00, ack);
    reset_active = 1;
    sendb(8'h77, ack); chk(!ack, "R9 data nack in reset", ack, 0);
    i_stop;
    i_start; sendb(WADR, ack); i_stop; chk(!ack, "R9 dev nack in reset", ack, 0);
    reset_active = 0; settle;
    rd_rand(16'h0200, 1); chk(rdat[0] == 8'h11, "R9 aborted write discarded", rdat[0], 8'h11);
    wdat[0] = 8'h99; wr(16'h0201, 1, "prog");
    reset_active = 1; repeat (100) @(negedge clk); reset_active = 0;
    i_start; sendb(WADR, ack); i_stop; chk(!ack, "R9 programming continues", ack, 0);
    settle;
    rd_rand(16'h0201, 1); chk(rdat[0] == 8'h99, "R9 programming committed", rdat[0], 8'h99);
  endtask

  initial begin
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    t_reset_and_addr;
    t_byte_write_poll;
    t_page_wrap;
    t_rollover;
    t_addr_only;
    t_reset_active;
    chk(viol == 0, "R10 SDA moved while SCL high", viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (199_000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule